// File: doc/BRIEF.md
# Four-Channel Ring-Buffer Byte DMA Engine

This block moves bytes between four slow byte-wide peripherals and a processor. All four channels share one buffer RAM. Each channel uses a circular region of that RAM, set by its base register and its span register. A peripheral asks for service by raising its request line. On each service step the engine either takes one byte from the peripheral into the channel's ring (inbound) or hands one byte from the ring to the peripheral (outbound).

The processor reaches every channel through one register port. The channel index sits in the address bits just above a 16-bit offset. Through this port the processor sets up the ring, picks the direction, masks the channel's interrupt, reads the byte tally, and pushes or pops ring bytes directly through a data window. The byte tally has two meanings. For an inbound channel it counts the bytes collected. For an outbound channel it counts the bytes still owed to the peripheral.

A single interrupt line combines the unmasked status flags of all channels. When several peripherals ask at once, a rotating arbiter grants one service step per clock. The processor's data window takes the shared RAM ahead of any service step.

Top module: `fq_dma_top`

## Requirements
- R1: After reset, every channel's span, base, mode, mask, status, tally and ring positions are zero; `irq`, both strobe vectors, `dev_wdata` and `cpu_rdata` are zero.
- R2: The channel is `cpu_addr[17:16]`, and `cpu_addr[15:0]` is the register offset: span 0x00, base 0x04, mode 0x0C, mask 0x18, masked status 0x1C (read only), tally 0x30 (read only), data window 0x34. A read loads `cpu_rdata`, zero-extended, at the clock edge of the access. The value then holds until the next read. Writes to read-only or unlisted offsets change nothing.
- R3: Mode bit 0 enables service steps and mode bit 1 selects the direction (1 = ring to peripheral, 0 = peripheral to ring). With bit 0 clear, a channel makes no steps whatever its request line does.
- R4: The read and write positions are offsets from the base. Each advances by one per access and returns to 0 when it would exceed the span, so a ring holds span+1 bytes. The RAM word used is (base + position) modulo the RAM depth.
- R5: An inbound step, taken while enabled and requested, pulses `dev_rd_stb` for one cycle and stores that cycle's `dev_rdata` byte at the write position. It also adds one to the tally and sets the status flag.
- R6: An outbound step needs the request line high and a nonzero tally. It pulses `dev_wr_stb` with the byte at the read position on `dev_wdata` and subtracts one from the tally. The step that brings the tally to zero sets the status flag, and no further steps follow.
- R7: A read of the data window returns the byte at the read position copied into all four byte lanes and advances the read position. If the tally is nonzero it drops by one, and reaching zero clears the status flag.
- R8: A write of the data window stores `cpu_wdata[7:0]` at the write position, adds one to the tally and advances the write position, without touching the status flag.
- R9: A mask write stores bit 0 and clears the channel's status flag. A service step on that channel in the same cycle still sets the flag. A status read returns flag AND mask.
- R10: `irq` is high exactly when some channel has both its status flag and its mask bit set.
- R11: At most one service step happens per clock. Among the ready channels, the grant goes to the first one found when searching upward (wrapping) from the channel granted last, and channel 0 counts as last granted after reset.
- R12: In a cycle where the processor reads or writes any data window, no channel makes a service step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 18 | Channel index [17:16], register offset [15:0] |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, loaded at the edge of a read |
| dev_drq | input | 4 | Per-channel service request level |
| dev_rdata | input | 32 | Per-channel inbound byte, channel n on bits 8n+7:8n |
| dev_rd_stb | output | 4 | Per-channel inbound byte taken this cycle |
| dev_wr_stb | output | 4 | Per-channel outbound byte offered this cycle |
| dev_wdata | output | 32 | Per-channel outbound byte, zero when not strobed |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two collisions can happen in one cycle. The processor can touch a data window while peripherals are requesting service, and a mask write can land on a channel in the cycle that channel is granted a step. The bench causes the first by reading a data window with an inbound request held high, and the second by writing the mask while a request is held. A behavioural reference model predicts the strobes, outbound bytes, `irq` and read data for every clock. For the collisions it expects no strobe at all in the window cycle, and a status flag that reads set after the mask write made during service.

// File: rtl/fq_pkg.sv
package fq_pkg;
   localparam int OFS_W = 16;
   localparam logic [OFS_W-1:0] OFS_SPAN  = 16'h0000;
   localparam logic [OFS_W-1:0] OFS_BASE  = 16'h0004;
   localparam logic [OFS_W-1:0] OFS_MODE  = 16'h000C;
   localparam logic [OFS_W-1:0] OFS_MASK  = 16'h0018;
   localparam logic [OFS_W-1:0] OFS_STAT  = 16'h001C;
   localparam logic [OFS_W-1:0] OFS_TALLY = 16'h0030;
   localparam logic [OFS_W-1:0] OFS_DATA  = 16'h0034;
   localparam int MODE_EN  = 0;
   localparam int MODE_OUT = 1;
   localparam int BYTE_W   = 8;
endpackage

// File: rtl/fq_ring_ram.sv
module fq_ring_ram #(
   parameter int DEPTH = 256,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/fq_rr_arb.sv
module fq_rr_arb #(
   parameter int N = 4,
   localparam int IW = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [IW-1:0] last_q;
   logic [IW-1:0] win;
   logic          found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      win   = last_q;
      for (int i = 1; i <= N; i++) begin
         int k;
         k = (int'(last_q) + i) % N;
         if (en && req[k] && !found) begin
            grant[k] = 1'b1;
            win      = IW'(k);
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= '0;
      else if (found) last_q <= win;
   end

   p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_grant_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   p_grant_rotates_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $countones(req) == N) |-> !grant[last_q]);
endmodule

// File: rtl/fq_channel.sv
module fq_channel #(
   parameter int AW    = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    cfg_wdata,
   input  logic             wr_span,
   input  logic             wr_base,
   input  logic             wr_mode,
   input  logic             wr_mask,
   input  logic             win_rd,
   input  logic             win_wr,
   input  logic             drq,
   input  logic             step,
   output logic             ready,
   output logic             dir_out,
   output logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    rd_addr,
   output logic [AW-1:0]    span_q,
   output logic [AW-1:0]    base_q,
   output logic [1:0]       mode_q,
   output logic             mask_q,
   output logic             stat_vis,
   output logic [CNT_W-1:0] tally_q,
   output logic             irq_req
);
   import fq_pkg::*;

   logic          stat_q, stat_d;
   logic [AW-1:0] wpos_q, rpos_q;
   logic          in_step, out_step;
   logic          tally_one, tally_zero;

   function automatic logic [AW-1:0] advance(input logic [AW-1:0] p, input logic [AW-1:0] lim);
      logic [AW:0] nxt;
      nxt = {1'b0, p} + 1'b1;
      return (nxt > {1'b0, lim}) ? '0 : nxt[AW-1:0];
   endfunction

   assign dir_out    = mode_q[MODE_OUT];
   assign in_step    = step && !dir_out;
   assign out_step   = step && dir_out;
   assign tally_zero = (tally_q == '0);
   assign tally_one  = (tally_q == CNT_W'(1));
   assign ready      = mode_q[MODE_EN] && drq && (!dir_out || !tally_zero);
   assign wr_addr    = base_q + wpos_q;
   assign rd_addr    = base_q + rpos_q;
   assign stat_vis   = stat_q & mask_q;
   assign irq_req    = stat_vis;

   always_comb begin
      stat_d = stat_q;
      if (wr_mask)                stat_d = 1'b0;
      if (win_rd && tally_one)    stat_d = 1'b0;
      if (in_step)                stat_d = 1'b1;
      if (out_step && tally_one)  stat_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span_q  <= '0;
         base_q  <= '0;
         mode_q  <= '0;
         mask_q  <= 1'b0;
         stat_q  <= 1'b0;
         tally_q <= '0;
         wpos_q  <= '0;
         rpos_q  <= '0;
      end else begin
         if (wr_span) span_q <= cfg_wdata;
         if (wr_base) base_q <= cfg_wdata;
         if (wr_mode) mode_q <= cfg_wdata[1:0];
         if (wr_mask) mask_q <= cfg_wdata[0];
         stat_q <= stat_d;
         if (win_wr || in_step)
            tally_q <= tally_q + 1'b1;
         else if (out_step || (win_rd && !tally_zero))
            tally_q <= tally_q - 1'b1;
         if (win_wr || in_step)  wpos_q <= advance(wpos_q, span_q);
         if (win_rd || out_step) rpos_q <= advance(rpos_q, span_q);
      end
   end

   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_step |-> !tally_zero);
   p_last_byte_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_step && tally_one) |=> (stat_q && tally_zero));
   p_inbound_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_step |=> (stat_q && tally_q == $past(tally_q) + CNT_W'(1)));
   p_mask_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask && !step) |=> !stat_q);
   p_step_only_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> mode_q[MODE_EN]);
endmodule

// File: rtl/fq_dma_top.sv
module fq_dma_top #(
   parameter int NUM_CH    = 4,
   parameter int RAM_DEPTH = 256,
   parameter int CNT_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cpu_sel,
   input  logic                          cpu_we,
   input  logic [15+$clog2(NUM_CH):0]    cpu_addr,
   input  logic [31:0]                   cpu_wdata,
   output logic [31:0]                   cpu_rdata,
   input  logic [NUM_CH-1:0]             dev_drq,
   input  logic [8*NUM_CH-1:0]           dev_rdata,
   output logic [NUM_CH-1:0]             dev_rd_stb,
   output logic [NUM_CH-1:0]             dev_wr_stb,
   output logic [8*NUM_CH-1:0]           dev_wdata,
   output logic                          irq
);
   import fq_pkg::*;

   localparam int CH_W = $clog2(NUM_CH);
   localparam int AW   = $clog2(RAM_DEPTH);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (RAM_DEPTH < 16 || (RAM_DEPTH & (RAM_DEPTH - 1)) != 0 || AW > 31) begin : g_bad_depth
      $error("RAM_DEPTH must be a power of two between 16 and 2^31");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end

   logic [CH_W-1:0]  sel_ch;
   logic [OFS_W-1:0] sel_ofs;
   logic             win_any;
   logic [NUM_CH-1:0] ready, grant, dir_out;
   logic [AW-1:0]    wr_addr [NUM_CH];
   logic [AW-1:0]    rd_addr [NUM_CH];
   logic [AW-1:0]    span_q  [NUM_CH];
   logic [AW-1:0]    base_q  [NUM_CH];
   logic [1:0]       mode_q  [NUM_CH];
   logic [NUM_CH-1:0] mask_q, stat_vis, irq_req;
   logic [CNT_W-1:0] tally_q [NUM_CH];
   logic [AW-1:0]    ram_addr;
   logic             ram_we;
   logic [7:0]       ram_wdata, ram_rdata, dev_byte;
   logic [AW-1:0]    step_addr;
   logic [31:0]      rd_mux;
   logic             unused_wdata;

   assign unused_wdata = ^cpu_wdata[31:AW];
   assign sel_ch  = cpu_addr[OFS_W +: CH_W];
   assign sel_ofs = cpu_addr[OFS_W-1:0];
   assign win_any = cpu_sel && (sel_ofs == OFS_DATA);

   fq_rr_arb #(.N(NUM_CH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!win_any),
      .req   (ready),
      .grant (grant)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = cpu_sel && (sel_ch == CH_W'(c));
      fq_channel #(.AW(AW), .CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_wdata (cpu_wdata[AW-1:0]),
         .wr_span   (hit && cpu_we && sel_ofs == OFS_SPAN),
         .wr_base   (hit && cpu_we && sel_ofs == OFS_BASE),
         .wr_mode   (hit && cpu_we && sel_ofs == OFS_MODE),
         .wr_mask   (hit && cpu_we && sel_ofs == OFS_MASK),
         .win_rd    (hit && !cpu_we && sel_ofs == OFS_DATA),
         .win_wr    (hit && cpu_we && sel_ofs == OFS_DATA),
         .drq       (dev_drq[c]),
         .step      (grant[c]),
         .ready     (ready[c]),
         .dir_out   (dir_out[c]),
         .wr_addr   (wr_addr[c]),
         .rd_addr   (rd_addr[c]),
         .span_q    (span_q[c]),
         .base_q    (base_q[c]),
         .mode_q    (mode_q[c]),
         .mask_q    (mask_q[c]),
         .stat_vis  (stat_vis[c]),
         .tally_q   (tally_q[c]),
         .irq_req   (irq_req[c])
      );
      assign dev_rd_stb[c]       = grant[c] && !dir_out[c];
      assign dev_wr_stb[c]       = grant[c] && dir_out[c];
      assign dev_wdata[8*c +: 8] = dev_wr_stb[c] ? ram_rdata : 8'h00;
   end

   always_comb begin
      step_addr = '0;
      dev_byte  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (grant[c]) begin
            step_addr = dir_out[c] ? rd_addr[c] : wr_addr[c];
            dev_byte  = dev_rdata[8*c +: 8];
         end
      end
   end

   always_comb begin
      if (win_any) begin
         ram_addr  = cpu_we ? wr_addr[sel_ch] : rd_addr[sel_ch];
         ram_we    = cpu_we;
         ram_wdata = cpu_wdata[7:0];
      end else begin
         ram_addr  = step_addr;
         ram_we    = |(grant & ~dir_out);
         ram_wdata = dev_byte;
      end
   end

   fq_ring_ram #(.DEPTH(RAM_DEPTH), .W(BYTE_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   always_comb begin
      unique case (sel_ofs)
         OFS_SPAN:  rd_mux = 32'(span_q[sel_ch]);
         OFS_BASE:  rd_mux = 32'(base_q[sel_ch]);
         OFS_MODE:  rd_mux = 32'(mode_q[sel_ch]);
         OFS_MASK:  rd_mux = 32'(mask_q[sel_ch]);
         OFS_STAT:  rd_mux = 32'(stat_vis[sel_ch]);
         OFS_TALLY: rd_mux = 32'(tally_q[sel_ch]);
         OFS_DATA:  rd_mux = {4{ram_rdata}};
         default:   rd_mux = 32'h0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_rdata <= '0;
      else if (cpu_sel && !cpu_we) cpu_rdata <= rd_mux;
   end

   assign irq = |irq_req;

   p_window_blocks_steps_r12: assert property (@(posedge clk) disable iff (!rst_n)
      win_any |-> (dev_rd_stb == '0 && dev_wr_stb == '0));
   p_single_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dev_rd_stb, dev_wr_stb}) <= 1);
   p_irq_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_vis != '0));
endmodule

// File: tb/tb_fq_dma_top.sv
module tb_fq_dma_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int DEPTH      = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel = 1'b0, cpu_we = 1'b0;
   logic [17:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic [3:0]  dev_drq = '0;
   logic [31:0] dev_rdata = '0;
   logic [3:0]  dev_rd_stb, dev_wr_stb;
   logic [31:0] dev_wdata;
   logic        irq;

   int n_checks = 0, n_fail = 0;
   string cur_tag = "R1";
   int cyc = 0;
   int rd_seen [4];
   int wr_seen [4];

   // reference model state
   int m_span [4], m_base [4], m_mode [4], m_mask [4], m_stat [4], m_tally [4], m_wp [4], m_rp [4];
   int m_mem [DEPTH];
   int m_last;
   logic [31:0] m_rdata;

   fq_dma_top dut (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dev_drq(dev_drq), .dev_rdata(dev_rdata),
      .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb), .dev_wdata(dev_wdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int nxt(input int p, input int s);
      return (p + 1 > s) ? 0 : p + 1;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 4; c++) begin
         m_span[c] = 0; m_base[c] = 0; m_mode[c] = 0; m_mask[c] = 0;
         m_stat[c] = 0; m_tally[c] = 0; m_wp[c] = 0; m_rp[c] = 0;
      end
      m_last = 0;
      m_rdata = '0;
   endtask

   // per-cycle reference comparison, sampled 2 time units after the falling edge
   always @(negedge clk) begin
      int ch, ofs, g, pa;
      bit win;
      logic [3:0] e_rd, e_wr;
      logic [31:0] e_wd;
      bit e_irq;
      int n_span, n_base, n_mode;
      bit w_span, w_base, w_mode;
      cyc++;
      dev_rdata = {8'(cyc + 8'hC0), 8'(cyc + 8'h80), 8'(cyc + 8'h40), 8'(cyc)};
      #2;
      ch  = int'(cpu_addr[17:16]);
      ofs = int'(cpu_addr[15:0]);
      win = cpu_sel && ofs == 'h34;
      g = -1;
      if (!win) begin
         for (int i = 1; i <= 4; i++) begin
            int k;
            k = (m_last + i) % 4;
            if (g < 0 && m_mode[k][0] && dev_drq[k] && (!m_mode[k][1] || m_tally[k] > 0)) g = k;
         end
      end
      e_rd = '0; e_wr = '0; e_wd = '0;
      if (g >= 0) begin
         if (m_mode[g][1]) begin
            e_wr[g] = 1'b1;
            e_wd[8*g +: 8] = 8'(m_mem[(m_base[g] + m_rp[g]) % DEPTH]);
         end else e_rd[g] = 1'b1;
      end
      e_irq = 0;
      for (int c = 0; c < 4; c++) if (m_stat[c] != 0 && m_mask[c] != 0) e_irq = 1;
      if (!rst_n) begin
         e_rd = '0; e_wr = '0; e_wd = '0; e_irq = 0;
      end
      check(dev_rd_stb === e_rd, cur_tag, "dev_rd_stb", 32'(dev_rd_stb), 32'(e_rd));
      check(dev_wr_stb === e_wr, cur_tag, "dev_wr_stb", 32'(dev_wr_stb), 32'(e_wr));
      check(dev_wdata === e_wd, cur_tag, "dev_wdata", dev_wdata, e_wd);
      check(irq === e_irq, cur_tag, "irq", 32'(irq), 32'(e_irq));
      check(cpu_rdata === m_rdata, cur_tag, "cpu_rdata", cpu_rdata, m_rdata);
      for (int c = 0; c < 4; c++) begin
         if (dev_rd_stb[c]) rd_seen[c]++;
         if (dev_wr_stb[c]) wr_seen[c]++;
      end
      if (!rst_n) model_reset();
      else begin
         w_span = 0; w_base = 0; w_mode = 0;
         n_span = 0; n_base = 0; n_mode = 0;
         if (cpu_sel && !cpu_we) begin
            case (ofs)
               'h00: m_rdata = 32'(m_span[ch]);
               'h04: m_rdata = 32'(m_base[ch]);
               'h0C: m_rdata = 32'(m_mode[ch]);
               'h18: m_rdata = 32'(m_mask[ch]);
               'h1C: m_rdata = 32'(m_stat[ch] & m_mask[ch]);
               'h30: m_rdata = 32'(m_tally[ch]);
               'h34: begin
                  pa = (m_base[ch] + m_rp[ch]) % DEPTH;
                  m_rdata = {4{8'(m_mem[pa])}};
                  if (m_tally[ch] > 0) begin
                     m_tally[ch]--;
                     if (m_tally[ch] == 0) m_stat[ch] = 0;
                  end
                  m_rp[ch] = nxt(m_rp[ch], m_span[ch]);
               end
               default: m_rdata = '0;
            endcase
         end
         if (cpu_sel && cpu_we) begin
            case (ofs)
               'h00: begin w_span = 1; n_span = int'(cpu_wdata[7:0]); end
               'h04: begin w_base = 1; n_base = int'(cpu_wdata[7:0]); end
               'h0C: begin w_mode = 1; n_mode = int'(cpu_wdata[1:0]); end
               'h18: begin m_mask[ch] = int'(cpu_wdata[0]); m_stat[ch] = 0; end
               'h34: begin
                  m_mem[(m_base[ch] + m_wp[ch]) % DEPTH] = int'(cpu_wdata[7:0]);
                  m_tally[ch] = (m_tally[ch] + 1) & 'hFFFF;
                  m_wp[ch] = nxt(m_wp[ch], m_span[ch]);
               end
               default: ;
            endcase
         end
         if (g >= 0) begin
            if (m_mode[g][1]) begin
               m_tally[g]--;
               if (m_tally[g] == 0) m_stat[g] = 1;
               m_rp[g] = nxt(m_rp[g], m_span[g]);
            end else begin
               m_mem[(m_base[g] + m_wp[g]) % DEPTH] = int'(dev_rdata[8*g +: 8]);
               m_tally[g] = (m_tally[g] + 1) & 'hFFFF;
               m_stat[g] = 1;
               m_wp[g] = nxt(m_wp[g], m_span[g]);
            end
            m_last = g;
         end
         if (w_span) m_span[ch] = n_span;
         if (w_base) m_base[ch] = n_base;
         if (w_mode) m_mode[ch] = n_mode;
      end
   end

   task automatic cpu_op(input bit we, input int ch, input int ofs, input logic [31:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = we; cpu_addr = {2'(ch), 16'(ofs)}; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic read_expect(input int ch, input int ofs, input logic [31:0] exp, input string tag);
      cpu_op(1'b0, ch, ofs, '0);
      #3;
      check(cpu_rdata === exp, tag, "register read", cpu_rdata, exp);
   endtask

   task automatic set_drq(input logic [3:0] v);
      @(negedge clk);
      dev_drq = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_all();
      // R1: reset state
      cur_tag = "R1";
      idle(2);
      check(irq === 1'b0 && dev_rd_stb === '0 && dev_wr_stb === '0, "R1", "outputs after reset",
            {irq, dev_rd_stb, dev_wr_stb}, '0);
      read_expect(0, 'h00, 0, "R1");
      read_expect(3, 'h30, 0, "R1");

      // R2: register map and ignored writes
      cur_tag = "R2";
      cpu_op(1, 2, 'h00, 32'h5);
      cpu_op(1, 2, 'h04, 32'h23);
      cpu_op(1, 2, 'h0C, 32'h3);
      cpu_op(1, 2, 'h18, 32'h1);
      cpu_op(1, 2, 'h30, 32'h9);
      cpu_op(1, 2, 'h1C, 32'h1);
      read_expect(2, 'h00, 32'h5, "R2");
      read_expect(2, 'h04, 32'h23, "R2");
      read_expect(2, 'h0C, 32'h3, "R2");
      read_expect(2, 'h18, 32'h1, "R2");
      read_expect(2, 'h30, 32'h0, "R2");
      read_expect(2, 'h1C, 32'h0, "R2");
      cpu_op(1, 2, 'h0C, 32'h0);

      // R8 and R4: window writes wrap a four-entry ring
      cur_tag = "R8/R4";
      cpu_op(1, 0, 'h00, 32'h3);
      cpu_op(1, 0, 'h04, 32'h10);
      for (int i = 0; i < 6; i++) cpu_op(1, 0, 'h34, 32'h11 + i);
      read_expect(0, 'h30, 32'd6, "R8");
      read_expect(0, 'h1C, 32'h0, "R8");
      cur_tag = "R7/R4";
      read_expect(0, 'h34, 32'h15151515, "R4");
      read_expect(0, 'h34, 32'h16161616, "R4");
      read_expect(0, 'h34, 32'h13131313, "R7");
      read_expect(0, 'h34, 32'h14141414, "R7");
      read_expect(0, 'h30, 32'd2, "R7");

      // R5, R10, R12: inbound service, window read under a held request
      cur_tag = "R5/R10/R12";
      cpu_op(1, 1, 'h00, 32'h7);
      cpu_op(1, 1, 'h04, 32'h40);
      cpu_op(1, 1, 'h18, 32'h1);
      cpu_op(1, 1, 'h0C, 32'h1);
      set_drq(4'b0010);
      idle(4);
      check(irq === 1'b1, "R10", "irq after inbound bytes", 32'(irq), 32'h1);
      cpu_op(0, 1, 'h34, '0);
      cpu_op(0, 1, 'h34, '0);
      set_drq(4'b0000);
      read_expect(1, 'h1C, 32'h1, "R9");
      cur_tag = "R7";
      for (int i = 0; i < 12; i++) cpu_op(0, 1, 'h34, '0);
      read_expect(1, 'h30, 32'h0, "R7");
      read_expect(1, 'h1C, 32'h0, "R7");
      check(irq === 1'b0, "R10", "irq after ring drained", 32'(irq), 32'h0);

      // R6: outbound service stops at zero tally
      cur_tag = "R6";
      cpu_op(1, 3, 'h00, 32'h4);
      cpu_op(1, 3, 'h04, 32'h80);
      cpu_op(1, 3, 'h34, 32'hA1);
      cpu_op(1, 3, 'h34, 32'hA2);
      cpu_op(1, 3, 'h34, 32'hA3);
      cpu_op(1, 3, 'h18, 32'h1);
      wr_seen[3] = 0;
      cpu_op(1, 3, 'h0C, 32'h3);
      set_drq(4'b1000);
      idle(6);
      set_drq(4'b0000);
      check(wr_seen[3] == 3, "R6", "outbound strobes", 32'(wr_seen[3]), 32'd3);
      read_expect(3, 'h30, 32'h0, "R6");
      read_expect(3, 'h1C, 32'h1, "R6");
      check(irq === 1'b1, "R6", "irq after last byte", 32'(irq), 32'h1);
      cpu_op(1, 3, 'h0C, 32'h0);
      cpu_op(1, 3, 'h18, 32'h0);

      // R11: three channels requesting together share evenly
      cur_tag = "R11";
      cpu_op(1, 0, 'h0C, 32'h1);
      cpu_op(1, 2, 'h0C, 32'h1);
      for (int c = 0; c < 4; c++) rd_seen[c] = 0;
      set_drq(4'b0111);
      repeat (9) @(negedge clk);
      dev_drq = 4'b0000;
      check(rd_seen[0] == 3, "R11", "ch0 grants", 32'(rd_seen[0]), 32'd3);
      check(rd_seen[1] == 3, "R11", "ch1 grants", 32'(rd_seen[1]), 32'd3);
      check(rd_seen[2] == 3, "R11", "ch2 grants", 32'(rd_seen[2]), 32'd3);

      // R9: mask write during a service step keeps the flag
      cur_tag = "R9";
      set_drq(4'b0010);
      idle(1);
      cpu_op(1, 1, 'h18, 32'h1);
      set_drq(4'b0000);
      read_expect(1, 'h1C, 32'h1, "R9");
      cpu_op(1, 1, 'h18, 32'h1);
      read_expect(1, 'h1C, 32'h0, "R9");

      // R3: disabled channel ignores its request
      cur_tag = "R3";
      cpu_op(1, 0, 'h0C, 32'h0);
      rd_seen[0] = 0;
      set_drq(4'b0001);
      idle(4);
      set_drq(4'b0000);
      check(rd_seen[0] == 0, "R3", "strobes while disabled", 32'(rd_seen[0]), 32'd0);
      read_expect(0, 'h30, 32'd5, "R3");
      idle(2);
   endtask

   initial begin
      bit done;
      done = 0;
      model_reset();
      for (int c = 0; c < 4; c++) begin rd_seen[c] = 0; wr_seen[c] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fork
         begin run_all(); done = 1; end
         begin repeat (WATCHDOG) @(posedge clk); end
      join_any
      disable fork;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule